// File: doc/BRIEF.md
# Module Slot Bus Access Controller

This block sits between a simple local-bus target port and four plug-in module slots. Each host access is decoded from its address. It goes either to the block's own control and status words or to one slot and one of three spaces in that slot: I/O, identification, or interrupt acknowledge. For a slot access the block drives the select line for that slot and space, along with the latched address, direction and write data. It then waits for that slot's acknowledge and returns the module's read data to the host.

The host must always get an answer. If the addressed module stays silent for a fixed time, derived from the system clock frequency and a timeout length in nanoseconds, the block ends the access itself. A read that ends this way returns all ones. A sticky per-slot timeout flag is set, and the flag raises the interrupt output when that slot's timeout-interrupt enable is set. Each slot also has a clock-rate select bit that goes straight to a pin.

Top module: `ipslot_access_ctrl`

## Requirements
- R1: Every accepted request gets exactly one `ack_o` pulse, one cycle wide. At most one of the select outputs (`io_sel_o`, `id_sel_o`, `int_sel_o`, all slots together) is high at any time.
- R2: With the top address bit clear, bits [9:8] pick the slot. Bit 7 = 0 selects I/O space. Bits [7:6] = 10 select ID space and 11 select interrupt space. For the last slot this gives I/O up to 0x37F, ID at 0x380–0x3BF and interrupt at 0x3C0–0x3FF.
- R3: A module cycle ends when the selected slot's `mod_ack_i` bit is high at a clock edge. `ack_o` follows in the next cycle, and for a read `rdata_o` then carries `mod_rdata_i`. Acknowledges from other slots are ignored.
- R4: If no acknowledge arrives within TIMEOUT cycles of the start (TIMEOUT = CLK_HZ × TIMEOUT_NS / 1e9), the access is ended and `ack_o` is given. A read then returns 0xFFFF. An acknowledge in the last counted cycle still completes normally.
- R5: A timeout sets bit n of the status word (address 0x408) for slot n. The bit stays set until it is cleared.
- R6: `irq_o` is high while any slot has both its timeout flag and its control bit 1 (timeout interrupt enable) set.
- R7: Writing the status word clears each flag whose write-data bit is 1. Flags with 0 written are unchanged.
- R8: Control word n (address 0x400 + 2n) holds bit 0 = fast clock (0 = 8 MHz, 1 = 32 MHz) and bit 1 = timeout interrupt enable. It reads back in bits [1:0], and bit 0 drives `clk_fast_o[n]`. A register access completes in one cycle.
- R9: During a module cycle, `mod_we_o`, `mod_wdata_o` and `mod_addr_o` (address bits [6:0]) carry the host request unchanged. This applies to writes to every space, including ID space.
- R10: After reset, all outputs are low and all control and status bits are zero.
- R11: Only one access is in progress at a time. A held request is not taken again in the cycle in which `ack_o` is high, which gives one idle cycle between back-to-back accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until `ack_o` |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 11 | Host byte address; bit 10 selects registers |
| wdata_i | input | 16 | Host write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| io_sel_o | output | 4 | Per-slot I/O space select |
| id_sel_o | output | 4 | Per-slot ID space select |
| int_sel_o | output | 4 | Per-slot interrupt space select |
| mod_we_o | output | 1 | Module cycle direction |
| mod_addr_o | output | 7 | Module address |
| mod_wdata_o | output | 16 | Module write data |
| mod_rdata_i | input | 16 | Module read data |
| mod_ack_i | input | 4 | Per-slot module acknowledge |
| clk_fast_o | output | 4 | Per-slot clock-rate select |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
The bench builds the block with CLK_HZ = 4 MHz and TIMEOUT_NS = 8000, which gives a 32-cycle timeout. With this setting every slot can be timed out several times in a short run. The exact boundary is tested from both sides: an acknowledge in the 32nd cycle and one a cycle late. A behavioural model follows every access and compares selects, module-side fields, acknowledge timing, read data, flags and the interrupt on every clock.

// File: rtl/ipsa_pkg.sv
package ipsa_pkg;
  typedef enum logic [1:0] {SP_IO = 2'd0, SP_ID = 2'd1, SP_INT = 2'd2} space_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_CYC = 1'b1} state_e;
  localparam int REG_IDX_W  = 3;
  localparam int MOD_ADDR_W = 7;
  localparam int CTRL_FAST  = 0;
  localparam int CTRL_TOIE  = 1;
endpackage

// File: rtl/ipsa_decode.sv
module ipsa_decode
  import ipsa_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int SLOT_W  = $clog2(N_SLOTS),
  parameter int ADDR_W  = SLOT_W + 9
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 is_reg_o,
  output logic [SLOT_W-1:0]    slot_o,
  output space_e               space_o,
  output logic [REG_IDX_W-1:0] reg_idx_o
);
  logic unused_addr;
  assign unused_addr = ^{addr_i[5:4], addr_i[0]};

  assign is_reg_o  = addr_i[ADDR_W-1];
  assign slot_o    = addr_i[8 +: SLOT_W];
  assign reg_idx_o = addr_i[3:1];

  always_comb begin
    if (!addr_i[7])     space_o = SP_IO;
    else if (!addr_i[6]) space_o = SP_ID;
    else                 space_o = SP_INT;
  end
endmodule

// File: rtl/ipsa_timer.sv
module ipsa_timer #(
  parameter int LIMIT = 256,
  parameter int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i)            cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LIMIT - 1));
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0));
endmodule

// File: rtl/ipsa_regs.sv
module ipsa_regs
  import ipsa_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [N_SLOTS-1:0]   set_i,
  output logic [DATA_W-1:0]    rd_o,
  output logic [N_SLOTS-1:0]   fast_o,
  output logic                 irq_o
);
  localparam logic [REG_IDX_W-1:0] STAT_IDX = REG_IDX_W'(N_SLOTS);
  localparam int USED_W = (N_SLOTS > 2) ? N_SLOTS : 2;

  logic [N_SLOTS-1:0] fast_q, ie_q, flag_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:USED_W];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fast_q[g] <= 1'b0;
        ie_q[g]   <= 1'b0;
      end else if (wr_i && idx_i == REG_IDX_W'(g)) begin
        fast_q[g] <= wdata_i[CTRL_FAST];
        ie_q[g]   <= wdata_i[CTRL_TOIE];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    flag_q[g] <= 1'b0;
      else if (set_i[g])                              flag_q[g] <= 1'b1;
      else if (wr_i && idx_i == STAT_IDX && wdata_i[g]) flag_q[g] <= 1'b0;
    end

    a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && idx_i == STAT_IDX && wdata_i[g] && !set_i[g]) |=> !flag_q[g]);
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !(wr_i && idx_i == STAT_IDX && wdata_i[g])) |=> flag_q[g]);
  end

  always_comb begin
    rd_o = '0;
    for (int n = 0; n < N_SLOTS; n++) begin
      if (idx_i == REG_IDX_W'(n)) begin
        rd_o[CTRL_FAST] = fast_q[n];
        rd_o[CTRL_TOIE] = ie_q[n];
      end
    end
    if (idx_i == STAT_IDX) rd_o[N_SLOTS-1:0] = flag_q;
  end

  assign fast_o = fast_q;
  assign irq_o  = |(flag_q & ie_q);
endmodule

// File: rtl/ipslot_access_ctrl.sv
module ipslot_access_ctrl
  import ipsa_pkg::*;
#(
  parameter int N_SLOTS    = 4,
  parameter int DATA_W     = 16,
  parameter int CLK_HZ     = 32_000_000,
  parameter int TIMEOUT_NS = 8000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [$clog2(N_SLOTS)+8:0]   addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic                         ack_o,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [N_SLOTS-1:0]           io_sel_o,
  output logic [N_SLOTS-1:0]           id_sel_o,
  output logic [N_SLOTS-1:0]           int_sel_o,
  output logic                         mod_we_o,
  output logic [MOD_ADDR_W-1:0]        mod_addr_o,
  output logic [DATA_W-1:0]            mod_wdata_o,
  input  logic [DATA_W-1:0]            mod_rdata_i,
  input  logic [N_SLOTS-1:0]           mod_ack_i,
  output logic [N_SLOTS-1:0]           clk_fast_o,
  output logic                         irq_o
);
  localparam int SLOT_W = $clog2(N_SLOTS);
  localparam int ADDR_W = SLOT_W + 9;
  localparam int TO_CYC = int'((longint'(CLK_HZ) * longint'(TIMEOUT_NS)) / 64'd1_000_000_000);

  state_e                state_q;
  logic [SLOT_W-1:0]     slot_q;
  space_e                space_q;
  logic                  we_q;
  logic [MOD_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;

  logic                  dec_reg;
  logic [SLOT_W-1:0]     dec_slot;
  space_e                dec_space;
  logic [REG_IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0]     reg_rd;
  logic                  take, reg_wr, mod_start, cyc, slot_ack, expire;
  logic [N_SLOTS-1:0]    to_set;

  ipsa_decode #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .is_reg_o (dec_reg),
    .slot_o   (dec_slot),
    .space_o  (dec_space),
    .reg_idx_o(dec_idx)
  );

  assign cyc       = (state_q == ST_CYC);
  assign take      = (state_q == ST_IDLE) && req_i && !ack_o;
  assign reg_wr    = take && dec_reg && we_i;
  assign mod_start = take && !dec_reg;
  assign slot_ack  = cyc && mod_ack_i[slot_q];
  assign to_set    = (cyc && !slot_ack && expire) ? (N_SLOTS'(1) << slot_q) : '0;

  ipsa_timer #(.LIMIT(TO_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mod_start),
    .run_i   (cyc),
    .expire_o(expire)
  );

  ipsa_regs #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr),
    .idx_i  (dec_idx),
    .wdata_i(wdata_i),
    .set_i  (to_set),
    .rd_o   (reg_rd),
    .fast_o (clk_fast_o),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ack_o   <= 1'b0;
      rdata_o <= '0;
      slot_q  <= '0;
      space_q <= SP_IO;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ack_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (dec_reg) begin
            ack_o <= 1'b1;
            if (!we_i) rdata_o <= reg_rd;
          end else begin
            state_q <= ST_CYC;
            slot_q  <= dec_slot;
            space_q <= dec_space;
            we_q    <= we_i;
            addr_q  <= addr_i[MOD_ADDR_W-1:0];
            wdata_q <= wdata_i;
          end
        end
        ST_CYC: begin
          if (slot_ack) begin
            state_q <= ST_IDLE;
            ack_o   <= 1'b1;
            if (!we_q) rdata_o <= mod_rdata_i;
          end else if (expire) begin
            state_q <= ST_IDLE;
            ack_o   <= 1'b1;
            if (!we_q) rdata_o <= '1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_sel
    assign io_sel_o[g]  = cyc && (slot_q == SLOT_W'(g)) && (space_q == SP_IO);
    assign id_sel_o[g]  = cyc && (slot_q == SLOT_W'(g)) && (space_q == SP_ID);
    assign int_sel_o[g] = cyc && (slot_q == SLOT_W'(g)) && (space_q == SP_INT);
  end

  assign mod_we_o    = we_q;
  assign mod_addr_o  = addr_q;
  assign mod_wdata_o = wdata_q;

  a_r1_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_sel_o, id_sel_o, int_sel_o}));
  a_r1_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r3_ack_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_ack |=> (ack_o && state_q == ST_IDLE));
  a_r3_read_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_ack && !we_q) |=> (rdata_o == $past(mod_rdata_i)));
  a_r4_timeout_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc && !slot_ack && expire && !we_q) |=> (ack_o && rdata_o == '1));
  a_r9_fields_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc && $past(cyc)) |-> ($stable(mod_addr_o) && $stable(mod_wdata_o) && $stable(mod_we_o)));
  a_r11_idle_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (state_q == ST_IDLE));
endmodule

// File: tb/ipslot_access_ctrl_tb_top.sv
module ipslot_access_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 11;
  localparam int T  = 32;  // 4 MHz x 8000 ns

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, mod_rdata = '0;
  logic [N-1:0]  mod_ack = '0;
  logic ack, mod_we, irq;
  logic [DW-1:0] rdata, mod_wdata;
  logic [N-1:0]  io_sel, id_sel, int_sel, clk_fast;
  logic [6:0]    mod_addr;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipslot_access_ctrl #(.N_SLOTS(N), .DATA_W(DW), .CLK_HZ(4_000_000), .TIMEOUT_NS(8000)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ack_o(ack), .rdata_o(rdata), .io_sel_o(io_sel), .id_sel_o(id_sel), .int_sel_o(int_sel),
    .mod_we_o(mod_we), .mod_addr_o(mod_addr), .mod_wdata_o(mod_wdata), .mod_rdata_i(mod_rdata),
    .mod_ack_i(mod_ack), .clk_fast_o(clk_fast), .irq_o(irq)
  );

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_we, m_ack, m_rd_ack;
  int m_slot, m_space, m_cnt;
  logic [DW-1:0] m_rdata, m_wdata;
  logic [6:0] m_addr;
  bit [N-1:0] m_flag, m_fast, m_ie;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_we = 0; m_ack = 0; m_rd_ack = 0; m_slot = 0; m_space = 0; m_cnt = 0;
      m_rdata = '0; m_wdata = '0; m_addr = '0; m_flag = '0; m_fast = '0; m_ie = '0;
    end else begin
      automatic bit old_ack = m_ack;
      m_ack = 0; m_rd_ack = 0;
      if (!m_busy) begin
        if (req && !old_ack) begin
          if (addr[10]) begin
            automatic int idx = int'(addr[3:1]);
            m_ack = 1;
            if (we) begin
              if (idx < N) begin m_fast[idx] = wdata[0]; m_ie[idx] = wdata[1]; end
              else if (idx == N) m_flag = m_flag & ~wdata[N-1:0];
            end else begin
              m_rd_ack = 1;
              if (idx < N) m_rdata = {14'd0, m_ie[idx], m_fast[idx]};
              else if (idx == N) m_rdata = {12'd0, m_flag};
              else m_rdata = '0;
            end
          end else begin
            m_busy = 1; m_cnt = 0; m_slot = int'(addr[9:8]);
            m_space = !addr[7] ? 0 : (!addr[6] ? 1 : 2);
            m_we = we; m_addr = addr[6:0]; m_wdata = wdata;
          end
        end
      end else begin
        if (mod_ack[m_slot]) begin
          m_busy = 0; m_ack = 1;
          if (!m_we) begin m_rd_ack = 1; m_rdata = mod_rdata; end
        end else if (m_cnt == T-1) begin
          m_busy = 0; m_ack = 1; m_flag[m_slot] = 1;
          if (!m_we) begin m_rd_ack = 1; m_rdata = '1; end
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic logic [11:0] exp_sel = '0;
    if (m_busy) exp_sel[m_space*4 + m_slot] = 1'b1;
    check("R2", "select vector", {int_sel, id_sel, io_sel}, exp_sel);
    check("R1", "ack timing", ack, m_ack);
    if (m_ack && m_rd_ack) check("R3", "read data", rdata, m_rdata);
    if (m_busy) begin
      check("R9", "module fields", {mod_we, mod_addr, mod_wdata}, {m_we, m_addr, m_wdata});
    end
    check("R6", "irq", irq, |(m_flag & m_ie));
    check("R8", "clock select", clk_fast, m_fast);
  end

  // module-side responder
  int lat[N];
  bit spur = 0;
  int resp_cnt = 0;
  always @(negedge clk) begin
    automatic logic [N-1:0] any = io_sel | id_sel | int_sel;
    mod_ack = '0;
    if (any != '0) begin
      automatic int s = 0;
      for (int i = 0; i < N; i++) if (any[i]) s = i;
      if (lat[s] >= 0 && resp_cnt == lat[s]) begin
        mod_ack[s] = 1'b1;
        mod_rdata = 16'hC000 + 16'(s * 256) + 16'(mod_addr);
      end
      if (spur) mod_ack[(s + 1) % N] = 1'b1;
      resp_cnt++;
    end else resp_cnt = 0;
  end

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int waits, output logic [11:0] sel_seen,
                        output logic [23:0] fields);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; waits = 0; sel_seen = '0; fields = '0;
    do begin
      @(negedge clk);
      waits++;
      if ((io_sel | id_sel | int_sel) != '0) begin
        sel_seen = {int_sel, id_sel, io_sel};
        fields = {mod_we, mod_addr, mod_wdata};
      end
    end while (!ack && waits < 200);
    rd = rdata;
    req = 0;
    @(negedge clk);
    check("R1", "ack one cycle wide", ack, 1'b0);
  endtask

  logic [DW-1:0] rd;
  int w;
  logic [11:0] sel;
  logic [23:0] f;

  initial begin
    for (int i = 0; i < N; i++) lat[i] = -1;
    repeat (3) @(negedge clk);
    check("R10", "reset outputs", {ack, rdata, io_sel, id_sel, int_sel, irq, clk_fast},
          '0);
    rst_n = 1;

    // R8 control word and clock select
    access(1, 11'h402, 16'h0001, rd, w, sel, f);
    check("R8", "reg access latency", w, 1);
    check("R8", "clk_fast after write", clk_fast, 4'b0010);
    access(0, 11'h402, 0, rd, w, sel, f);
    check("R8", "ctrl readback", rd, 16'h0001);

    // R3 / R2 I/O read with latency 2
    lat[0] = 2;
    access(0, 11'h005, 0, rd, w, sel, f);
    check("R3", "io read data", rd, 16'hC005);
    check("R3", "ack latency", w, 4);
    check("R2", "io select slot0", sel, 12'h001);

    // R9 ID write forwarded
    lat[2] = 0;
    access(1, 11'h2A4, 16'h1234, rd, w, sel, f);
    check("R2", "id select slot2", sel, 12'h040);
    check("R9", "id write fields", f, {1'b1, 7'h24, 16'h1234});

    // R2 interrupt space and last-slot boundaries
    lat[3] = 1;
    access(0, 11'h3C0, 0, rd, w, sel, f);
    check("R2", "int select slot3", sel, 12'h800);
    check("R3", "int read data", rd, 16'hC340);
    access(0, 11'h37F, 0, rd, w, sel, f);
    check("R2", "0x37F is io", sel, 12'h008);
    access(0, 11'h380, 0, rd, w, sel, f);
    check("R2", "0x380 is id", sel, 12'h080);
    access(0, 11'h3BF, 0, rd, w, sel, f);
    check("R2", "0x3BF is id", sel, 12'h080);

    // R4 / R5 timeout on slot1
    access(0, 11'h100, 0, rd, w, sel, f);
    check("R4", "timeout read ones", rd, 16'hFFFF);
    check("R4", "timeout latency", w, T + 1);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R5", "status after timeout", rd, 16'h0002);
    check("R6", "irq masked", irq, 1'b0);

    // R6 enable, R7 write-one-to-clear
    access(1, 11'h402, 16'h0003, rd, w, sel, f);
    check("R6", "irq enabled", irq, 1'b1);
    access(1, 11'h408, 16'h0000, rd, w, sel, f);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R7", "zero write keeps flag", rd, 16'h0002);
    access(1, 11'h408, 16'h0002, rd, w, sel, f);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R7", "one write clears flag", rd, 16'h0000);
    check("R6", "irq after clear", irq, 1'b0);

    // R4 boundary: ack in last counted cycle vs one late
    lat[0] = T - 1;
    access(0, 11'h010, 0, rd, w, sel, f);
    check("R4", "ack at last cycle data", rd, 16'hC010);
    check("R4", "ack at last cycle latency", w, T + 1);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R4", "no flag at last cycle", rd, 16'h0000);
    lat[0] = T;
    access(0, 11'h010, 0, rd, w, sel, f);
    check("R4", "one late times out", rd, 16'hFFFF);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R5", "flag slot0", rd, 16'h0001);
    access(1, 11'h408, 16'h000F, rd, w, sel, f);

    // R3 other slot's ack ignored
    lat[0] = -1; spur = 1;
    access(0, 11'h000, 0, rd, w, sel, f);
    check("R3", "foreign ack ignored", rd, 16'hFFFF);
    spur = 0;

    // R5 write timeout on slot2
    lat[2] = -1;
    access(1, 11'h210, 16'hBEEF, rd, w, sel, f);
    access(0, 11'h408, 0, rd, w, sel, f);
    check("R5", "flags after write timeout", rd, 16'h0005);

    // R11 held request: one idle cycle between accesses
    begin
      automatic int acks = 0;
      @(negedge clk);
      req = 1; we = 0; addr = 11'h400;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (ack) acks++;
      end
      req = 0;
      check("R11", "acks over 6 held cycles", acks, 3);
    end
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule